// File: doc/BRIEF.md
# Drive Command and DMA Register Block

This block is the bus-facing register file in front of a storage-drive command engine. Software loads three command words, an aligned DMA address and an aligned DMA length. It then writes the control register with its start bit set. The block sends a one-cycle start pulse to the engine and presents the command words, address and length on dedicated outputs. While the start bit stays high, the command counts as in flight.

When the engine reports completion, the block takes the following actions:
- It clears the start bit.
- It zeroes the length.
- It can capture an immediate reply word.
- It sets an interrupt flag chosen by the completion type.

Each of the four interrupt sources has a flag and a mask. The single interrupt output is high while any flag and its mask are both set. A separate cover register holds the fourth flag/mask pair, and its flag is set by an external cover event.

Top module: `drive_dma_regs`

## Requirements
- R1: After reset, every register reads zero except the configuration register, which reads 1. The interrupt and start outputs are low.
- R2: A write to the DMA address register (word 5) stores the value with bits 0–4 and 26–31 forced to zero. A write to the DMA length register (word 6) stores the value with bits 0–4 forced to zero.
- R3: The control register (word 7) keeps only the low 3 bits of a write. Bit 0 is the start bit. A write with bit 0 set, accepted while the start bit is clear, raises `cmdStart` for exactly the one cycle after the write edge.
- R4: While the start bit is set, writes to the control register are ignored: the stored value does not change and no start pulse is issued.
- R5: When `doneValid` is high and the start bit is set, the block clears the start bit and zeroes the length register. The other control bits are kept. The block also sets one status flag according to `doneType`: 0 sets the transfer-complete flag (bit 4), 1 sets the device-error flag (bit 2), 2 sets the break flag (bit 6), and 3 sets none. A completion while the start bit is clear has no effect.
- R6: In the status register (word 0), a write copies bit 0 (break request) and the masks at bits 1, 3 and 5 from the write data. Writing 1 to a flag bit (2, 4 or 6) clears that flag, and writing 0 leaves it unchanged. A completion in the same cycle sets its flag even if the write clears it.
- R7: `irq` is high exactly when at least one pair is fully set. The pairs are: status bits 2 and 1, status bits 4 and 3, status bits 6 and 5, and cover-register bits 1 (flag) and 0 (mask).
- R8: The command words (words 2, 3, 4) and the immediate-data register (word 8) are plain read/write. An accepted completion with `doneImmValid` high loads `doneImm` into the immediate-data register.
- R9: The configuration register (word 9) is read-only, and bus writes to it do not change it.
- R10: A `coverEvt` pulse sets the cover flag (cover register word 1, bit 1). Writing 1 to that bit clears the flag, and bit 0 of a cover write sets the mask.
- R11: A read returns the addressed register combinationally in the same cycle as `busRd`. Unmapped words, and any cycle without `busRd`, return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWr | input | 1 | Register write strobe |
| busRd | input | 1 | Register read strobe |
| busAddr | input | 4 | Word index of the register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid in the read cycle |
| cmdStart | output | 1 | One-cycle command launch pulse |
| cmdWord0 | output | 32 | Command word 0 |
| cmdWord1 | output | 32 | Command word 1 |
| cmdWord2 | output | 32 | Command word 2 |
| cmdAddr | output | 32 | Aligned DMA address |
| cmdLen | output | 32 | Aligned DMA length |
| doneValid | input | 1 | Completion report from the engine |
| doneType | input | 2 | Completion type (0 transfer, 1 device error, 2 break, 3 none) |
| doneImmValid | input | 1 | Completion carries an immediate reply |
| doneImm | input | 32 | Immediate reply word |
| coverEvt | input | 1 | Cover event, sets the cover flag |
| irq | output | 1 | Combined masked interrupt |

## Verification
The assertions check the following on every cycle:
- The address and length outputs never hold a bit that alignment forbids.
- The start pulse never lasts longer than one cycle.
- Every pulse, and every rise of the busy state, traces back to an accepted control write.
- An accepted completion always leaves the block idle with a zero length.
- The interrupt stays low whenever all four masks are clear.

Only the bench scenarios can show the following:
- Which flag each completion type sets.
- That write-one-to-clear preserves the masks.
- That ignored writes and ignored completions leave the registers untouched.
- That immediate replies are captured.

// File: rtl/drive_dma_pkg.sv
package drive_dma_pkg;
  localparam int REG_AW   = 4;
  localparam int NUM_CMD  = 3;

  localparam logic [REG_AW-1:0] REG_STATUS = 4'd0;
  localparam logic [REG_AW-1:0] REG_COVER  = 4'd1;
  localparam logic [REG_AW-1:0] REG_CMD0   = 4'd2;
  localparam logic [REG_AW-1:0] REG_ADDR   = 4'd5;
  localparam logic [REG_AW-1:0] REG_LEN    = 4'd6;
  localparam logic [REG_AW-1:0] REG_CTL    = 4'd7;
  localparam logic [REG_AW-1:0] REG_IMM    = 4'd8;
  localparam logic [REG_AW-1:0] REG_CFG    = 4'd9;

  localparam int ST_W   = 7;
  localparam int ST_BRK = 0;
  localparam int ST_DEM = 1;
  localparam int ST_DEF = 2;
  localparam int ST_TCM = 3;
  localparam int ST_TCF = 4;
  localparam int ST_BKM = 5;
  localparam int ST_BKF = 6;

  localparam int CV_MASK = 0;
  localparam int CV_FLAG = 1;

  localparam int CTL_W     = 3;
  localparam int CTL_START = 0;

  typedef enum logic [1:0] {
    CMPL_XFER   = 2'd0,
    CMPL_DEVERR = 2'd1,
    CMPL_BREAK  = 2'd2,
    CMPL_NONE   = 2'd3
  } cmplType_e;

  typedef struct packed {
    logic               wrStatus;
    logic               wrCover;
    logic [NUM_CMD-1:0] wrCmd;
    logic               wrAddr;
    logic               wrLen;
    logic               wrCtl;
    logic               wrImm;
    logic               complete;
  } regStrobe_t;
endpackage

// File: rtl/drive_dma_ctrl.sv
module drive_dma_ctrl
  import drive_dma_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic [REG_AW-1:0] busAddr,
  input  logic              wrStartBit,
  input  logic              doneValid,
  input  logic              busy,
  output regStrobe_t        strobes,
  output logic              cmdStart
);
  logic launch;

  always_comb begin
    strobes          = '0;
    strobes.wrStatus = busWr && (busAddr == REG_STATUS);
    strobes.wrCover  = busWr && (busAddr == REG_COVER);
    strobes.wrAddr   = busWr && (busAddr == REG_ADDR);
    strobes.wrLen    = busWr && (busAddr == REG_LEN);
    strobes.wrCtl    = busWr && (busAddr == REG_CTL) && !busy;
    strobes.wrImm    = busWr && (busAddr == REG_IMM);
    strobes.complete = doneValid && busy;
    for (int i = 0; i < NUM_CMD; i++) begin
      strobes.wrCmd[i] = busWr && (busAddr == REG_CMD0 + REG_AW'(i));
    end
  end

  assign launch = strobes.wrCtl && wrStartBit;

  always_ff @(posedge clk) begin
    if (!rstN) cmdStart <= 1'b0;
    else       cmdStart <= launch;
  end
endmodule

// File: rtl/drive_dma_datapath.sv
module drive_dma_datapath
  import drive_dma_pkg::*;
#(
  parameter int DW        = 32,
  parameter int ALIGN_LSB = 5,
  parameter int ADDR_BITS = 26,
  parameter logic [DW-1:0] CFG_RESET = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  regStrobe_t        strobes,
  input  logic              busRd,
  input  logic [REG_AW-1:0] busAddr,
  input  logic [DW-1:0]     busWdata,
  output logic [DW-1:0]     busRdata,
  input  logic [1:0]        doneType,
  input  logic              doneImmValid,
  input  logic [DW-1:0]     doneImm,
  input  logic              coverEvt,
  output logic [DW-1:0]     cmdWord [NUM_CMD],
  output logic [DW-1:0]     addrQ,
  output logic [DW-1:0]     lenQ,
  output logic [ST_W-1:0]   statusQ,
  output logic [1:0]        coverQ,
  output logic              busy,
  output logic              irq
);
  localparam logic [DW-1:0] LOW_CLR  = {{(DW-ALIGN_LSB){1'b1}}, {ALIGN_LSB{1'b0}}};
  localparam logic [DW-1:0] HIGH_CLR = {{(DW-ADDR_BITS){1'b0}}, {ADDR_BITS{1'b1}}};
  localparam logic [DW-1:0] ADDR_KEEP = LOW_CLR & HIGH_CLR;

  logic [CTL_W-1:0] ctlQ;
  logic [DW-1:0]    immQ;
  logic [DW-1:0]    cfgQ;
  logic [ST_W-1:0]  statusD;
  logic [1:0]       coverD;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_CMD; gi++) begin : g_cmd
      always_ff @(posedge clk) begin
        if (!rstN)                   cmdWord[gi] <= '0;
        else if (strobes.wrCmd[gi])  cmdWord[gi] <= busWdata;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN)               addrQ <= '0;
    else if (strobes.wrAddr) addrQ <= busWdata & ADDR_KEEP;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                 lenQ <= '0;
    else if (strobes.complete) lenQ <= '0;
    else if (strobes.wrLen)    lenQ <= busWdata & LOW_CLR;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                 ctlQ <= '0;
    else if (strobes.complete) ctlQ[CTL_START] <= 1'b0;
    else if (strobes.wrCtl)    ctlQ <= busWdata[CTL_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN)                                   immQ <= '0;
    else if (strobes.complete && doneImmValid)   immQ <= doneImm;
    else if (strobes.wrImm)                      immQ <= busWdata;
  end

  always_ff @(posedge clk) begin
    if (!rstN) cfgQ <= CFG_RESET;
  end

  always_comb begin
    statusD = statusQ;
    if (strobes.wrStatus) begin
      statusD[ST_BRK] = busWdata[ST_BRK];
      statusD[ST_DEM] = busWdata[ST_DEM];
      statusD[ST_TCM] = busWdata[ST_TCM];
      statusD[ST_BKM] = busWdata[ST_BKM];
      if (busWdata[ST_DEF]) statusD[ST_DEF] = 1'b0;
      if (busWdata[ST_TCF]) statusD[ST_TCF] = 1'b0;
      if (busWdata[ST_BKF]) statusD[ST_BKF] = 1'b0;
    end
    if (strobes.complete) begin
      case (cmplType_e'(doneType))
        CMPL_XFER:   statusD[ST_TCF] = 1'b1;
        CMPL_DEVERR: statusD[ST_DEF] = 1'b1;
        CMPL_BREAK:  statusD[ST_BKF] = 1'b1;
        default:     ;
      endcase
    end
  end

  always_comb begin
    coverD = coverQ;
    if (strobes.wrCover) begin
      coverD[CV_MASK] = busWdata[CV_MASK];
      if (busWdata[CV_FLAG]) coverD[CV_FLAG] = 1'b0;
    end
    if (coverEvt) coverD[CV_FLAG] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusQ <= '0;
      coverQ  <= '0;
    end else begin
      statusQ <= statusD;
      coverQ  <= coverD;
    end
  end

  assign busy = ctlQ[CTL_START];

  assign irq = (statusQ[ST_DEF] & statusQ[ST_DEM]) |
               (statusQ[ST_TCF] & statusQ[ST_TCM]) |
               (statusQ[ST_BKF] & statusQ[ST_BKM]) |
               (coverQ[CV_FLAG] & coverQ[CV_MASK]);

  always_comb begin
    busRdata = '0;
    if (busRd) begin
      case (busAddr)
        REG_STATUS: busRdata = DW'(statusQ);
        REG_COVER:  busRdata = DW'(coverQ);
        REG_ADDR:   busRdata = addrQ;
        REG_LEN:    busRdata = lenQ;
        REG_CTL:    busRdata = DW'(ctlQ);
        REG_IMM:    busRdata = immQ;
        REG_CFG:    busRdata = cfgQ;
        default: begin
          for (int i = 0; i < NUM_CMD; i++) begin
            if (busAddr == REG_CMD0 + REG_AW'(i)) busRdata = cmdWord[i];
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/drive_dma_regs.sv
module drive_dma_regs
  import drive_dma_pkg::*;
#(
  parameter int DW        = 32,
  parameter int ALIGN_LSB = 5,
  parameter int ADDR_BITS = 26
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [REG_AW-1:0] busAddr,
  input  logic [DW-1:0]     busWdata,
  output logic [DW-1:0]     busRdata,
  output logic              cmdStart,
  output logic [DW-1:0]     cmdWord0,
  output logic [DW-1:0]     cmdWord1,
  output logic [DW-1:0]     cmdWord2,
  output logic [DW-1:0]     cmdAddr,
  output logic [DW-1:0]     cmdLen,
  input  logic              doneValid,
  input  logic [1:0]        doneType,
  input  logic              doneImmValid,
  input  logic [DW-1:0]     doneImm,
  input  logic              coverEvt,
  output logic              irq
);
  regStrobe_t      strobes;
  logic            busyQ;
  logic [ST_W-1:0] statusQ;
  logic [1:0]      coverQ;
  logic [DW-1:0]   cmdWord [NUM_CMD];

  drive_dma_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr),
    .wrStartBit(busWdata[CTL_START]), .doneValid(doneValid), .busy(busyQ),
    .strobes(strobes), .cmdStart(cmdStart)
  );

  drive_dma_datapath #(.DW(DW), .ALIGN_LSB(ALIGN_LSB), .ADDR_BITS(ADDR_BITS)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .busRd(busRd), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .doneType(doneType),
    .doneImmValid(doneImmValid), .doneImm(doneImm), .coverEvt(coverEvt),
    .cmdWord(cmdWord), .addrQ(cmdAddr), .lenQ(cmdLen), .statusQ(statusQ),
    .coverQ(coverQ), .busy(busyQ), .irq(irq)
  );

  assign cmdWord0 = cmdWord[0];
  assign cmdWord1 = cmdWord[1];
  assign cmdWord2 = cmdWord[2];
endmodule

// File: rtl/drive_dma_regs_chk.sv
module drive_dma_regs_chk
  import drive_dma_pkg::*;
#(
  parameter int DW        = 32,
  parameter int ALIGN_LSB = 5,
  parameter int ADDR_BITS = 26
) (
  input logic              clk,
  input logic              rstN,
  input logic              busWr,
  input logic [REG_AW-1:0] busAddr,
  input logic [DW-1:0]     busWdata,
  input logic              cmdStart,
  input logic [DW-1:0]     cmdAddr,
  input logic [DW-1:0]     cmdLen,
  input logic              doneValid,
  input logic              busyQ,
  input logic [ST_W-1:0]   statusQ,
  input logic [1:0]        coverQ,
  input logic              irq
);
  // R2
  addr_align_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdAddr[ALIGN_LSB-1:0] == '0) && (cmdAddr[DW-1:ADDR_BITS] == '0));
  // R2
  len_align_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdLen[ALIGN_LSB-1:0] == '0);
  // R3
  start_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdStart |=> !cmdStart);
  // R4
  start_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdStart |-> $past(busWr && busAddr == REG_CTL && busWdata[CTL_START] && !busyQ));
  // R3
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busyQ) |-> cmdStart);
  // R5
  complete_chk: assert property (@(posedge clk) disable iff (!rstN)
    (doneValid && busyQ) |=> (!busyQ && cmdLen == '0));
  // R7
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!statusQ[ST_DEM] && !statusQ[ST_TCM] && !statusQ[ST_BKM] && !coverQ[CV_MASK]) |-> !irq);
endmodule

bind drive_dma_regs drive_dma_regs_chk #(.DW(DW), .ALIGN_LSB(ALIGN_LSB), .ADDR_BITS(ADDR_BITS)) u_chk (
  .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr), .busWdata(busWdata),
  .cmdStart(cmdStart), .cmdAddr(cmdAddr), .cmdLen(cmdLen), .doneValid(doneValid),
  .busyQ(busyQ), .statusQ(statusQ), .coverQ(coverQ), .irq(irq)
);

// File: tb/drive_dma_regs_tb.sv
module drive_dma_regs_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWr = 1'b0, busRd = 1'b0;
  logic [3:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        cmdStart;
  logic [31:0] cmdWord0, cmdWord1, cmdWord2, cmdAddr, cmdLen;
  logic        doneValid = 1'b0;
  logic [1:0]  doneType = '0;
  logic        doneImmValid = 1'b0;
  logic [31:0] doneImm = '0;
  logic        coverEvt = 1'b0;
  logic        irq;

  int nChecks = 0;
  int nFails  = 0;

  always #4 clk = ~clk;

  drive_dma_regs u_dut (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busRd(busRd), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .cmdStart(cmdStart),
    .cmdWord0(cmdWord0), .cmdWord1(cmdWord1), .cmdWord2(cmdWord2),
    .cmdAddr(cmdAddr), .cmdLen(cmdLen), .doneValid(doneValid), .doneType(doneType),
    .doneImmValid(doneImmValid), .doneImm(doneImm), .coverEvt(coverEvt), .irq(irq)
  );

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWr = 1'b0; busWdata = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    busRd = 1'b1; busAddr = a;
    #1 d = busRdata;
    busRd = 1'b0;
  endtask

  task automatic complete(input logic [1:0] t, input logic iv, input logic [31:0] imm);
    @(negedge clk);
    doneValid = 1'b1; doneType = t; doneImmValid = iv; doneImm = imm;
    @(negedge clk);
    doneValid = 1'b0; doneImmValid = 1'b0;
  endtask

  task automatic expectReg(input string req, input logic [3:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    check(req, $sformatf("reg %0d", a), v, exp);
  endtask

  task automatic t_reset;
    expectReg("R1", 4'd0, 32'h0);
    expectReg("R1", 4'd5, 32'h0);
    expectReg("R1", 4'd6, 32'h0);
    expectReg("R1", 4'd7, 32'h0);
    expectReg("R1", 4'd8, 32'h0);
    expectReg("R1", 4'd9, 32'h1);
    check("R1", "irq", {31'b0, irq}, 32'h0);
    check("R1", "cmdStart", {31'b0, cmdStart}, 32'h0);
  endtask

  task automatic t_align;
    wr(4'd5, 32'hFFFF_FFFF);
    expectReg("R2", 4'd5, 32'h03FF_FFE0);
    wr(4'd6, 32'hFFFF_FFFF);
    expectReg("R2", 4'd6, 32'hFFFF_FFE0);
    wr(4'd5, 32'h1234_567F);
    check("R2", "cmdAddr", cmdAddr, 32'h0234_5660);
  endtask

  task automatic t_plain;
    logic [31:0] v;
    wr(4'd2, 32'hA1A1_0001);
    wr(4'd3, 32'hB2B2_0002);
    wr(4'd4, 32'hC3C3_0003);
    expectReg("R8", 4'd2, 32'hA1A1_0001);
    expectReg("R8", 4'd3, 32'hB2B2_0002);
    expectReg("R8", 4'd4, 32'hC3C3_0003);
    wr(4'd8, 32'h5555_AAAA);
    expectReg("R8", 4'd8, 32'h5555_AAAA);
    wr(4'd9, 32'h0);
    expectReg("R9", 4'd9, 32'h1);
    expectReg("R11", 4'd15, 32'h0);
    @(negedge clk);
    busAddr = 4'd2; #1 v = busRdata;
    check("R11", "no strobe", v, 32'h0);
  endtask

  task automatic t_launch;
    wr(4'd6, 32'h0000_0400);
    wr(4'd7, 32'hFFFF_FFFF);
    check("R3", "cmdStart pulse", {31'b0, cmdStart}, 32'h1);
    check("R3", "cmdWord1", cmdWord1, 32'hB2B2_0002);
    check("R3", "cmdLen", cmdLen, 32'h0000_0400);
    @(negedge clk);
    check("R3", "cmdStart low", {31'b0, cmdStart}, 32'h0);
    expectReg("R3", 4'd7, 32'h7);
    wr(4'd7, 32'h0000_0003);
    check("R4", "no pulse", {31'b0, cmdStart}, 32'h0);
    expectReg("R4", 4'd7, 32'h7);
  endtask

  task automatic t_complete;
    wr(4'd0, 32'h0000_0008);
    expectReg("R6", 4'd0, 32'h8);
    complete(2'd0, 1'b1, 32'hCAFE_F00D);
    expectReg("R5", 4'd7, 32'h6);
    expectReg("R5", 4'd6, 32'h0);
    expectReg("R5", 4'd0, 32'h18);
    check("R7", "irq xfer", {31'b0, irq}, 32'h1);
    expectReg("R8", 4'd8, 32'hCAFE_F00D);
    wr(4'd0, 32'h0000_0018);
    expectReg("R6", 4'd0, 32'h8);
    check("R7", "irq cleared", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_ignored;
    wr(4'd6, 32'h0000_0040);
    complete(2'd1, 1'b1, 32'h1111_2222);
    expectReg("R5", 4'd0, 32'h8);
    expectReg("R5", 4'd6, 32'h40);
    expectReg("R5", 4'd8, 32'hCAFE_F00D);
  endtask

  task automatic t_types;
    wr(4'd7, 32'h1);
    check("R3", "relaunch", {31'b0, cmdStart}, 32'h1);
    complete(2'd1, 1'b0, 32'h0);
    expectReg("R5", 4'd0, 32'h0C);
    check("R7", "devErr unmasked", {31'b0, irq}, 32'h0);
    wr(4'd0, 32'h0000_000A);
    check("R7", "devErr masked", {31'b0, irq}, 32'h1);
    wr(4'd0, 32'h0000_0004);
    wr(4'd0, 32'h0000_0020);
    wr(4'd7, 32'h1);
    complete(2'd2, 1'b0, 32'h0);
    expectReg("R5", 4'd0, 32'h60);
    check("R7", "break", {31'b0, irq}, 32'h1);
    wr(4'd0, 32'h0000_0061);
    expectReg("R6", 4'd0, 32'h21);
    wr(4'd7, 32'h1);
    complete(2'd3, 1'b0, 32'h0);
    expectReg("R5", 4'd0, 32'h21);
    expectReg("R5", 4'd7, 32'h0);
    wr(4'd0, 32'h0);
  endtask

  task automatic t_cover;
    wr(4'd1, 32'h1);
    check("R7", "mask only", {31'b0, irq}, 32'h0);
    @(negedge clk); coverEvt = 1'b1;
    @(negedge clk); coverEvt = 1'b0;
    expectReg("R10", 4'd1, 32'h3);
    check("R7", "cover irq", {31'b0, irq}, 32'h1);
    wr(4'd1, 32'h3);
    expectReg("R10", 4'd1, 32'h1);
    check("R10", "cover cleared", {31'b0, irq}, 32'h0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rstN = 1'b1;
        t_reset();
        t_align();
        t_plain();
        t_launch();
        t_complete();
        t_ignored();
        t_types();
        t_cover();
      end
      begin
        repeat (20000) @(posedge clk);
        nChecks++; nFails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule